// File: doc/BRIEF.md
# Camera Crop and Fractional Downscaler

This block sits on a raw pixel stream coming from an image sensor front end. Each input beat carries one pixel, qualified by a valid strobe, and may be tagged as the first pixel of a line or the first pixel of a frame. The block cuts a rectangular window out of every frame and then shrinks that window by a rational ratio, using a separate numerator/denominator pair for columns and for rows. Pixels that survive leave the block unchanged in value and order, with fresh line and frame markers that describe the reduced picture.

Decimation follows an error-accumulator scheme: every windowed pixel (or windowed row, for the vertical direction) adds the numerator to an accumulator, and the pixel is kept only when the accumulator reaches the denominator, which is then subtracted. A frame-rate reducer can keep one frame out of every K. All settings are captured at the start of each frame, so a frame is never processed with a mix of old and new values. An illegal ratio raises an error flag, and the frame then passes through the window without being shrunk.

Top module: `cam_crop_scaler`

## Requirements
- R1: After reset out_valid, out_sof, out_sol and cfg_err are 0, and beats that arrive before the first in_sof beat are never emitted.
- R2: A beat is emitted only if its column lies in [cfg_x0, cfg_x0+cfg_w) and its row in [cfg_y0, cfg_y0+cfg_h); the column is 0 on a beat with in_sol or in_sof and counts up by one per valid beat, the row is 0 on the in_sof beat and counts up by one on every later in_sol beat.
- R3: Horizontal step: an accumulator restarts at 0 on column cfg_x0 of every line; each windowed pixel adds cfg_h_num, and the pixel is kept when the sum is at least cfg_h_den, in which case cfg_h_den is subtracted; equal numerator and denominator keep every column.
- R4: Vertical step: the same rule applied once per windowed row with cfg_v_num and cfg_v_den, the accumulator restarting at 0 at every frame; a pixel is emitted only if both its row and its column are kept.
- R5: Emitted pixels keep their input order and data; out_sol is high on the first emitted pixel of each line, out_sof is high (together with out_sol) on the first emitted pixel of each frame, and neither marker is high without out_valid.
- R6: All cfg_* inputs are sampled on the in_sof beat only; changing them during a frame has no effect on that frame.
- R7: A ratio pair with denominator 0 or numerator greater than denominator makes the frame invalid: cfg_err is 1 from the cycle after that frame's in_sof beat until the next in_sof beat, and every windowed pixel of the frame is emitted unscaled.
- R8: With cfg_keep_every K of 0 or 1 every frame is kept; otherwise a frame counter, starting at 0 after reset, keeps a frame when it reads 0 and wraps after K-1, so the first frame and then every K-th frame are kept.
- R9: An emitted pixel appears on the outputs exactly two clock cycles after its input beat, and cycles with in_valid low create no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat carries a pixel |
| in_sof | input | 1 | First pixel of a frame (also starts a line) |
| in_sol | input | 1 | First pixel of a line |
| in_data | input | DW | Pixel value |
| cfg_x0 | input | XW | First column of the window |
| cfg_y0 | input | YW | First row of the window |
| cfg_w | input | XW | Window width in pixels |
| cfg_h | input | YW | Window height in rows |
| cfg_h_num | input | 8 | Horizontal ratio numerator |
| cfg_h_den | input | 8 | Horizontal ratio denominator |
| cfg_v_num | input | 8 | Vertical ratio numerator |
| cfg_v_den | input | 8 | Vertical ratio denominator |
| cfg_keep_every | input | KW | Keep one frame in this many (0 or 1: all) |
| out_valid | output | 1 | Output beat carries a kept pixel |
| out_sof | output | 1 | First kept pixel of a frame |
| out_sol | output | 1 | First kept pixel of a line |
| out_data | output | DW | Kept pixel value |
| cfg_err | output | 1 | Ratio settings of the current frame are illegal |

## Verification
A wrong column or row counter shifts the window, which shows on the very first line of the frame as a pixel value that does not match the expected one, or as a missing or surplus beat. A corrupted accumulator changes which columns or rows survive, so the mismatch appears at the next kept pixel of that line or frame, while a lost restart shows only on the second line or second frame, which is why the bench always runs several lines and consecutive frames. A stale shadow setting or a bad frame counter shows one frame later, as a whole frame that appears or vanishes, and a marker fault shows at the first pixel of the affected line.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int RATIO_W = 8;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    ratio_t n;
    ratio_t m;
  } ratio_pair_t;

  function automatic logic pair_bad(ratio_pair_t p);
    return (p.m == '0) || (p.n > p.m);
  endfunction

endpackage

// File: rtl/ccs_ratio_step.sv
module ccs_ratio_step
  import ccs_pkg::*;
#(
  parameter int AW = RATIO_W
) (
  input  logic [AW:0]   acc,
  input  logic          restart,
  input  logic [AW-1:0] n,
  input  logic [AW-1:0] m,
  output logic          keep,
  output logic [AW:0]   acc_nx
);

  logic [AW:0] base;
  logic [AW:0] sum;

  always_comb begin
    base   = restart ? '0 : acc;
    sum    = base + {1'b0, n};
    keep   = (sum >= {1'b0, m});
    acc_nx = keep ? (sum - {1'b0, m}) : sum;
  end

endmodule

// File: rtl/ccs_front.sv
module ccs_front
  import ccs_pkg::*;
#(
  parameter int XW = 13,
  parameter int YW = 12,
  parameter int DW = 8,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [DW-1:0] in_data,
  input  logic [XW-1:0] cfg_x0,
  input  logic [YW-1:0] cfg_y0,
  input  logic [XW-1:0] cfg_w,
  input  logic [YW-1:0] cfg_h,
  input  ratio_pair_t   cfg_hr,
  input  ratio_pair_t   cfg_vr,
  input  logic [KW-1:0] cfg_keep,
  output logic          a_valid,
  output logic          a_sof,
  output logic          a_sol,
  output logic [DW-1:0] a_data,
  output logic [XW-1:0] a_x,
  output logic [YW-1:0] a_y,
  output logic          a_fkeep,
  output logic [XW-1:0] sh_x0,
  output logic [YW-1:0] sh_y0,
  output logic [XW-1:0] sh_w,
  output logic [YW-1:0] sh_h,
  output ratio_pair_t   sh_hr,
  output ratio_pair_t   sh_vr,
  output logic          sh_err
);

  logic [KW-1:0] fcnt;
  logic          line_start;
  logic [XW-1:0] x_nx;
  logic [YW-1:0] y_nx;
  logic          keep_all;
  logic          frame_keep;
  logic [KW-1:0] fcnt_nx;

  always_comb begin
    line_start = in_sof | in_sol;
    x_nx       = line_start ? '0 : a_x + XW'(1);
    if (in_sof)      y_nx = '0;
    else if (in_sol) y_nx = a_y + YW'(1);
    else             y_nx = a_y;
    keep_all   = (cfg_keep <= KW'(1));
    frame_keep = keep_all || (fcnt == '0);
    fcnt_nx    = (keep_all || (fcnt >= cfg_keep - KW'(1))) ? '0 : fcnt + KW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_sof   <= 1'b0;
      a_sol   <= 1'b0;
      a_data  <= '0;
      a_x     <= '0;
      a_y     <= '0;
      a_fkeep <= 1'b0;
      fcnt    <= '0;
      sh_x0   <= '0;
      sh_y0   <= '0;
      sh_w    <= '0;
      sh_h    <= '0;
      sh_hr   <= '0;
      sh_vr   <= '0;
      sh_err  <= 1'b0;
    end else begin
      a_valid <= in_valid;
      a_sof   <= in_valid & in_sof;
      a_sol   <= in_valid & line_start;
      if (in_valid) begin
        a_data <= in_data;
        a_x    <= x_nx;
        a_y    <= y_nx;
        if (in_sof) begin
          sh_x0   <= cfg_x0;
          sh_y0   <= cfg_y0;
          sh_w    <= cfg_w;
          sh_h    <= cfg_h;
          sh_hr   <= cfg_hr;
          sh_vr   <= cfg_vr;
          sh_err  <= pair_bad(cfg_hr) | pair_bad(cfg_vr);
          a_fkeep <= frame_keep;
          fcnt    <= fcnt_nx;
        end
      end
    end
  end

endmodule

// File: rtl/ccs_decim.sv
module ccs_decim
  import ccs_pkg::*;
#(
  parameter int XW = 13,
  parameter int YW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_valid,
  input  logic          a_sof,
  input  logic          a_sol,
  input  logic [DW-1:0] a_data,
  input  logic [XW-1:0] a_x,
  input  logic [YW-1:0] a_y,
  input  logic          a_fkeep,
  input  logic [XW-1:0] sh_x0,
  input  logic [YW-1:0] sh_y0,
  input  logic [XW-1:0] sh_w,
  input  logic [YW-1:0] sh_h,
  input  ratio_pair_t   sh_hr,
  input  ratio_pair_t   sh_vr,
  input  logic          sh_err,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_sol,
  output logic [DW-1:0] out_data
);

  localparam int AW = RATIO_W;

  logic [AW:0] hacc, hacc_nx;
  logic [AW:0] vacc, vacc_nx;
  logic        h_step_keep, v_step_keep;
  logic        col_in, row_in;
  logic        row_keep_now, line_keep_q;
  logic        pix_keep;
  logic        sof_pend, sol_pend;

  always_comb begin
    col_in = (a_x >= sh_x0) &&
             ({1'b0, a_x} < ({1'b0, sh_x0} + {1'b0, sh_w}));
    row_in = (a_y >= sh_y0) &&
             ({1'b0, a_y} < ({1'b0, sh_y0} + {1'b0, sh_h}));
  end

  ccs_ratio_step #(.AW(AW)) h_step_i (
    .acc     (hacc),
    .restart (a_x == sh_x0),
    .n       (sh_hr.n),
    .m       (sh_hr.m),
    .keep    (h_step_keep),
    .acc_nx  (hacc_nx)
  );

  ccs_ratio_step #(.AW(AW)) v_step_i (
    .acc     (vacc),
    .restart (a_sof),
    .n       (sh_vr.n),
    .m       (sh_vr.m),
    .keep    (v_step_keep),
    .acc_nx  (vacc_nx)
  );

  always_comb begin
    row_keep_now = a_sol ? (row_in && (sh_err || v_step_keep)) : line_keep_q;
    pix_keep     = a_valid && a_fkeep && col_in && row_keep_now &&
                   (sh_err || h_step_keep);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hacc        <= '0;
      vacc        <= '0;
      line_keep_q <= 1'b0;
      sof_pend    <= 1'b0;
      sol_pend    <= 1'b0;
      out_valid   <= 1'b0;
      out_sof     <= 1'b0;
      out_sol     <= 1'b0;
      out_data    <= '0;
    end else begin
      if (a_valid) begin
        if (a_sol) begin
          line_keep_q <= row_keep_now;
          if (row_in)     vacc <= vacc_nx;
          else if (a_sof) vacc <= '0;
        end
        if (col_in) hacc <= hacc_nx;
      end
      if (pix_keep) begin
        sof_pend <= 1'b0;
        sol_pend <= 1'b0;
      end else begin
        if (a_valid && a_sof) sof_pend <= 1'b1;
        if (a_valid && a_sol) sol_pend <= 1'b1;
      end
      out_valid <= pix_keep;
      out_sof   <= pix_keep & (a_sof | sof_pend);
      out_sol   <= pix_keep & (a_sol | sol_pend);
      out_data  <= a_data;
    end
  end

endmodule

// File: rtl/cam_crop_scaler.sv
module cam_crop_scaler
  import ccs_pkg::*;
#(
  parameter int MAX_W = 4096,
  parameter int MAX_H = 2048,
  parameter int DW    = 8,
  parameter int KW    = 4,
  localparam int XW   = $clog2(MAX_W) + 1,
  localparam int YW   = $clog2(MAX_H) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_sol,
  input  logic [DW-1:0]      in_data,
  input  logic [XW-1:0]      cfg_x0,
  input  logic [YW-1:0]      cfg_y0,
  input  logic [XW-1:0]      cfg_w,
  input  logic [YW-1:0]      cfg_h,
  input  logic [RATIO_W-1:0] cfg_h_num,
  input  logic [RATIO_W-1:0] cfg_h_den,
  input  logic [RATIO_W-1:0] cfg_v_num,
  input  logic [RATIO_W-1:0] cfg_v_den,
  input  logic [KW-1:0]      cfg_keep_every,
  output logic               out_valid,
  output logic               out_sof,
  output logic               out_sol,
  output logic [DW-1:0]      out_data,
  output logic               cfg_err
);

  ratio_pair_t   hr_in, vr_in;
  ratio_pair_t   sh_hr, sh_vr;
  logic          a_valid, a_sof, a_sol, a_fkeep;
  logic [DW-1:0] a_data;
  logic [XW-1:0] a_x, sh_x0, sh_w;
  logic [YW-1:0] a_y, sh_y0, sh_h;
  logic          sh_err;

  assign hr_in   = '{n: cfg_h_num, m: cfg_h_den};
  assign vr_in   = '{n: cfg_v_num, m: cfg_v_den};
  assign cfg_err = sh_err;

  ccs_front #(.XW(XW), .YW(YW), .DW(DW), .KW(KW)) front_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_sol   (in_sol),
    .in_data  (in_data),
    .cfg_x0   (cfg_x0),
    .cfg_y0   (cfg_y0),
    .cfg_w    (cfg_w),
    .cfg_h    (cfg_h),
    .cfg_hr   (hr_in),
    .cfg_vr   (vr_in),
    .cfg_keep (cfg_keep_every),
    .a_valid  (a_valid),
    .a_sof    (a_sof),
    .a_sol    (a_sol),
    .a_data   (a_data),
    .a_x      (a_x),
    .a_y      (a_y),
    .a_fkeep  (a_fkeep),
    .sh_x0    (sh_x0),
    .sh_y0    (sh_y0),
    .sh_w     (sh_w),
    .sh_h     (sh_h),
    .sh_hr    (sh_hr),
    .sh_vr    (sh_vr),
    .sh_err   (sh_err)
  );

  ccs_decim #(.XW(XW), .YW(YW), .DW(DW)) decim_i (
    .clk       (clk),
    .rst       (rst),
    .a_valid   (a_valid),
    .a_sof     (a_sof),
    .a_sol     (a_sol),
    .a_data    (a_data),
    .a_x       (a_x),
    .a_y       (a_y),
    .a_fkeep   (a_fkeep),
    .sh_x0     (sh_x0),
    .sh_y0     (sh_y0),
    .sh_w      (sh_w),
    .sh_h      (sh_h),
    .sh_hr     (sh_hr),
    .sh_vr     (sh_vr),
    .sh_err    (sh_err),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_data  (out_data)
  );

endmodule

// File: rtl/ccs_chk.sv
module ccs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_sof,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_sol,
  input logic [DW-1:0] out_data,
  input logic          cfg_err
);

  // R5
  frame_mark_has_line_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> out_sol);

  // R5
  marks_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_sol) |-> out_valid);

  // R9
  output_has_source_beat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R9
  data_passes_unchanged_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == $past(in_data, 2)));

  // R7
  err_moves_only_after_sof_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid && in_sof) |-> $stable(cfg_err));

endmodule

bind cam_crop_scaler ccs_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_sol   (out_sol),
  .out_data  (out_data),
  .cfg_err   (cfg_err)
);

// File: tb/cam_crop_scaler_tb_top.sv
module cam_crop_scaler_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [7:0]  in_data = '0;
  logic [12:0] cfg_x0 = '0, cfg_w = '0;
  logic [11:0] cfg_y0 = '0, cfg_h = '0;
  logic [7:0]  cfg_h_num = '0, cfg_h_den = '0, cfg_v_num = '0, cfg_v_den = '0;
  logic [3:0]  cfg_keep_every = '0;
  logic        out_valid, out_sof, out_sol, cfg_err;
  logic [7:0]  out_data;

  typedef struct packed {
    logic       sof;
    logic       sol;
    logic [7:0] data;
    int         cyc;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    fcnt_m = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cam_crop_scaler dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_data(in_data),
    .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_w(cfg_w), .cfg_h(cfg_h),
    .cfg_h_num(cfg_h_num), .cfg_h_den(cfg_h_den),
    .cfg_v_num(cfg_v_num), .cfg_v_den(cfg_v_den),
    .cfg_keep_every(cfg_keep_every),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_data(out_data), .cfg_err(cfg_err)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  // Monitor: pops the scoreboard on every output beat (R5, R9).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected pixel got data %h expected none", cur_req, out_data);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (out_data !== e.data || out_sof !== e.sof || out_sol !== e.sol || cyc != e.cyc) begin
          fails++;
          $display("FAIL %s/R5/R9: got data %h sof %0b sol %0b cyc %0d expected data %h sof %0b sol %0b cyc %0d",
                   cur_req, out_data, out_sof, out_sol, cyc, e.data, e.sof, e.sol, e.cyc);
        end
      end
    end
  end

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic drain(string req);
    repeat (5) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: got %0d pixels still missing expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  // Driver: sends one frame and pushes the expected kept pixels.
  task automatic run_frame(int iw, int ih, int x0, int y0, int w, int h,
                           int hn, int hm, int vn, int vm, int k, bit scramble);
    bit fkeep, err, first_f, first_l, row_in, col_in, vk, hk;
    int vacc, hacc, s;
    fkeep = (k <= 1) || (fcnt_m == 0);
    fcnt_m = ((k <= 1) || (fcnt_m >= k - 1)) ? 0 : fcnt_m + 1;
    err = (hm == 0) || (hn > hm) || (vm == 0) || (vn > vm);
    first_f = 1'b1;
    vacc = 0;
    hacc = 0;
    for (int y = 0; y < ih; y++) begin
      row_in = (y >= y0) && (y < y0 + h);
      vk = 1'b0;
      if (row_in) begin
        if (err) vk = 1'b1;
        else begin
          s = vacc + vn;
          vk = (s >= vm);
          vacc = vk ? s - vm : s;
        end
      end
      first_l = 1'b1;
      for (int x = 0; x < iw; x++) begin
        if ((x + y) % 5 == 4) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sof = 1'b0;
          in_sol = 1'b0;
        end
        @(negedge clk);
        if (x == 0 && y == 0) begin
          cfg_x0 = 13'(x0); cfg_y0 = 12'(y0); cfg_w = 13'(w); cfg_h = 12'(h);
          cfg_h_num = 8'(hn); cfg_h_den = 8'(hm);
          cfg_v_num = 8'(vn); cfg_v_den = 8'(vm);
          cfg_keep_every = 4'(k);
        end else if (scramble) begin
          cfg_x0 = 13'd0; cfg_y0 = 12'd0; cfg_w = 13'd1; cfg_h = 12'd1;
          cfg_h_num = 8'd1; cfg_h_den = 8'd0;
          cfg_v_num = 8'd1; cfg_v_den = 8'd7;
          cfg_keep_every = 4'd2;
        end
        in_valid = 1'b1;
        in_sof = (x == 0 && y == 0);
        in_sol = (x == 0);
        in_data = 8'(y * 16 + x);
        col_in = (x >= x0) && (x < x0 + w);
        hk = 1'b0;
        if (col_in) begin
          if (err) hk = 1'b1;
          else begin
            s = ((x == x0) ? 0 : hacc) + hn;
            hk = (s >= hm);
            hacc = hk ? s - hm : s;
          end
        end
        if (fkeep && row_in && col_in && vk && hk) begin
          expq.push_back('{sof: first_f, sol: first_l, data: 8'(y * 16 + x), cyc: cyc + 2});
          first_f = 1'b0;
          first_l = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_sol = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_bit("R1 out_valid", out_valid, 1'b0);
    check_bit("R1 out_sof", out_sof, 1'b0);
    check_bit("R1 out_sol", out_sol, 1'b0);
    check_bit("R1 cfg_err", cfg_err, 1'b0);
    // R1: beats before the first frame start are dropped
    cfg_w = 13'd20; cfg_h = 12'd12;
    cfg_h_num = 8'd1; cfg_h_den = 8'd1; cfg_v_num = 8'd1; cfg_v_den = 8'd1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol = (i == 0);
      in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sol = 1'b0;
    drain("R1 pre-frame");

    cur_req = "R2 passthrough";
    run_frame(20, 12, 0, 0, 20, 12, 1, 1, 1, 1, 0, 0);
    drain(cur_req);

    cur_req = "R2 crop window";
    run_frame(20, 12, 3, 2, 8, 5, 4, 4, 9, 9, 1, 0);
    drain(cur_req);

    cur_req = "R3 horizontal 2/3";
    run_frame(20, 12, 1, 0, 17, 12, 2, 3, 1, 1, 0, 0);
    drain(cur_req);

    cur_req = "R3 horizontal 255/255";
    run_frame(20, 6, 0, 0, 20, 6, 255, 255, 1, 1, 0, 0);
    drain(cur_req);

    cur_req = "R4 vertical 1/2";
    run_frame(20, 12, 0, 1, 20, 10, 1, 1, 1, 2, 0, 0);
    drain(cur_req);

    cur_req = "R4 both 3/5 and 2/7";
    run_frame(20, 12, 2, 1, 15, 11, 3, 5, 2, 7, 0, 0);
    run_frame(20, 12, 2, 1, 15, 11, 3, 5, 2, 7, 0, 0);
    drain(cur_req);

    cur_req = "R5 sparse lines 1/4";
    run_frame(20, 12, 5, 3, 3, 8, 1, 4, 1, 3, 0, 0);
    drain(cur_req);

    cur_req = "R6 mid-frame changes ignored";
    run_frame(20, 12, 4, 2, 10, 7, 2, 5, 3, 4, 0, 1);
    drain(cur_req);
    check_bit("R6 cfg_err unchanged", cfg_err, 1'b0);

    cur_req = "R7 zero denominator";
    run_frame(20, 8, 2, 1, 9, 5, 1, 0, 1, 3, 0, 0);
    drain(cur_req);
    check_bit("R7 cfg_err raised", cfg_err, 1'b1);

    cur_req = "R7 numerator above denominator";
    run_frame(20, 8, 0, 0, 6, 4, 1, 2, 5, 4, 0, 0);
    drain(cur_req);
    check_bit("R7 cfg_err held", cfg_err, 1'b1);

    cur_req = "R7 recovery";
    run_frame(20, 8, 0, 0, 20, 8, 1, 2, 1, 1, 0, 0);
    drain(cur_req);
    check_bit("R7 cfg_err cleared", cfg_err, 1'b0);

    cur_req = "R8 keep one in three";
    for (int f = 0; f < 6; f++) run_frame(12, 4, 0, 0, 12, 4, 1, 1, 1, 1, 3, 0);
    drain(cur_req);

    cur_req = "R8 keep all again";
    run_frame(12, 4, 0, 0, 12, 4, 1, 2, 1, 1, 1, 0);
    run_frame(12, 4, 0, 0, 12, 4, 1, 2, 1, 1, 0, 0);
    drain(cur_req);

    finish_run();
  end

endmodule